// File: doc/BRIEF.md
# Flash Erase Block Select Registers

This block holds the two byte-wide control registers that choose which one flash block an erase may touch. Software writes a one-hot pattern through a small register bus: a low register covers blocks 0 to 7 and a high register covers blocks 8 to 11. The block drives a 12-bit block-enable vector and an erase-permitted flag to the erase sequencer. It also enforces the protection rules, so the sequencer can trust both outputs without further checks.

Several status inputs clear the registers or hold them at zero: system standby, hardware standby, the flash write-enable pin, the software write-enable bit and a restricted operating mode. When on-chip flash is switched off, the registers read zero, the block enables are masked and writes are dropped. A write that would leave two enable bits set across the pair is refused whole.

Top module: `erase_blk_sel`

## Requirements
- R1: While rst_ni is low, both registers are zero: reads at both addresses return 0x00, blk_en_o is 0 and erase_ok_o is 0.
- R2: When hw_stby_i or sw_stby_i is high, or wr_pin_i is low, both registers become zero at the next rising edge. This takes priority over a write in the same cycle.
- R3: While wr_pin_i is high and sw_wen_i is low, the low register is held at zero and writes to it are ignored. The high register keeps its value and stays writable.
- R4: Address 0 is the low register, whose bit n enables block n (blk_en_o[n], n = 0..7). Address 1 is the high register, whose bits 3:0 enable blocks 8..11 (blk_en_o[11:8]). Bits 7:4 of the high register read 0, and writes to them are ignored.
- R5: A write that would leave more than one enable bit set across both registers is rejected, and both registers keep their previous contents. A write of 0x00 is always accepted.
- R6: While flash_on_i is low, every read returns 0x00, blk_en_o is 0, erase_ok_o is 0 and writes are ignored.
- R7: While prog_lock_i is high, the low register is held at zero and none of its bits can be set.
- R8: erase_ok_o is 1 only when exactly one enable bit is set, flash_on_i is high, wr_pin_i and sw_wen_i are high, and neither standby input is high.
- R9: An accepted write takes effect at the rising clock edge. Reads are combinational from bus_addr_i.
- R10: Addresses 2 and 3 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_stby_i | input | 1 | Hardware standby, clears both registers |
| sw_stby_i | input | 1 | Software standby, clears both registers |
| wr_pin_i | input | 1 | Flash write-enable pin level |
| sw_wen_i | input | 1 | Software write-enable control bit |
| flash_on_i | input | 1 | On-chip flash enabled |
| prog_lock_i | input | 1 | Operating mode without on-board programming |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| blk_en_o | output | 12 | Per-block erase enable |
| erase_ok_o | output | 1 | Erase permitted |

## Verification
The assertions take for granted that every status and bus input is steady from one rising edge to the next, and that reset is held low across the first clock edge. Under these conditions the next-state properties may sample the inputs of the previous cycle. The bench drives all inputs only on falling edges and asserts reset from time zero. In random cycles the standby, pin, mode and flash-off conditions are kept rare, and the write data is mostly zero or one-hot, so that both accepted writes and rejected writes occur often.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int DATA_W  = 8;
  localparam int LO_W    = 8;
  localparam int HI_W    = 4;
  localparam int ADDR_W  = 2;
  localparam int LO_ADDR = 0;
  localparam int HI_ADDR = 1;

  typedef struct packed {
    logic clr_all;  // standby or pin low: wipe both registers
    logic lo_hold;  // low register forced to zero
    logic wr_ok;    // bus writes may land
    logic qual;     // erase qualifiers met
  } ebs_ctl_t;
endpackage

// File: rtl/ebs_cond.sv
module ebs_cond
  import ebs_pkg::*;
(
  input  logic     hw_stby_i,
  input  logic     sw_stby_i,
  input  logic     wr_pin_i,
  input  logic     sw_wen_i,
  input  logic     flash_on_i,
  input  logic     prog_lock_i,
  output ebs_ctl_t ctl_o
);
  always_comb begin
    ctl_o.clr_all = hw_stby_i | sw_stby_i | ~wr_pin_i;
    ctl_o.lo_hold = (wr_pin_i & ~sw_wen_i) | prog_lock_i;
    ctl_o.wr_ok   = flash_on_i & ~ctl_o.clr_all;
    ctl_o.qual    = flash_on_i & wr_pin_i & sw_wen_i & ~hw_stby_i & ~sw_stby_i;
  end
endmodule

// File: rtl/ebs_wr.sv
module ebs_wr
  import ebs_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LW  = LO_W,
  parameter int HW  = HI_W,
  parameter int AW  = ADDR_W,
  parameter int LOA = LO_ADDR,
  parameter int HIA = HI_ADDR
) (
  input  ebs_ctl_t       ctl_i,
  input  logic [LW-1:0]  lo_q_i,
  input  logic [HW-1:0]  hi_q_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           we_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [LW-1:0]  lo_d_o,
  output logic [HW-1:0]  hi_d_o
);
  logic [LW-1:0] base_lo, cand_lo;
  logic [HW-1:0] cand_hi;
  logic          hit_lo, hit_hi, multi;

  always_comb begin
    base_lo = ctl_i.lo_hold ? '0 : lo_q_i;
    hit_lo  = we_i && ctl_i.wr_ok && !ctl_i.lo_hold && (addr_i == AW'(LOA));
    hit_hi  = we_i && ctl_i.wr_ok && (addr_i == AW'(HIA));
    cand_lo = hit_lo ? wdata_i[LW-1:0] : base_lo;
    cand_hi = hit_hi ? wdata_i[HW-1:0] : hi_q_i;
    multi   = $countones({cand_hi, cand_lo}) > 1;
    if (ctl_i.clr_all) begin
      lo_d_o = '0;
      hi_d_o = '0;
    end else if (multi) begin
      lo_d_o = base_lo;
      hi_d_o = hi_q_i;
    end else begin
      lo_d_o = cand_lo;
      hi_d_o = cand_hi;
    end
  end
endmodule

// File: rtl/ebs_regs.sv
module ebs_regs #(
  parameter int LW = 8,
  parameter int HW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] lo_d_i,
  input  logic [HW-1:0] hi_d_i,
  output logic [LW-1:0] lo_q_o,
  output logic [HW-1:0] hi_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q_o <= '0;
      hi_q_o <= '0;
    end else begin
      lo_q_o <= lo_d_i;
      hi_q_o <= hi_d_i;
    end
  end
endmodule

// File: rtl/ebs_rd.sv
module ebs_rd
  import ebs_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LW  = LO_W,
  parameter int HW  = HI_W,
  parameter int AW  = ADDR_W,
  parameter int LOA = LO_ADDR,
  parameter int HIA = HI_ADDR,
  localparam int NB = LW + HW
) (
  input  ebs_ctl_t       ctl_i,
  input  logic           flash_on_i,
  input  logic [LW-1:0]  lo_q_i,
  input  logic [HW-1:0]  hi_q_i,
  input  logic [AW-1:0]  addr_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NB-1:0]  blk_en_o,
  output logic           erase_ok_o
);
  logic [NB-1:0] all_q;
  assign all_q = {hi_q_i, lo_q_i};

  always_comb begin
    rdata_o = '0;
    if (flash_on_i) begin
      if (addr_i == AW'(LOA))      rdata_o = DW'(lo_q_i);
      else if (addr_i == AW'(HIA)) rdata_o = DW'(hi_q_i);
    end
  end

  for (genvar g = 0; g < NB; g++) begin : g_mask
    assign blk_en_o[g] = all_q[g] & flash_on_i;
  end

  assign erase_ok_o = ctl_i.qual & $onehot(all_q);
endmodule

// File: rtl/erase_blk_sel.sv
module erase_blk_sel
  import ebs_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int LW  = LO_W,
  parameter int HW  = HI_W,
  parameter int AW  = ADDR_W,
  parameter int LOA = LO_ADDR,
  parameter int HIA = HI_ADDR,
  localparam int NB = LW + HW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_stby_i,
  input  logic          sw_stby_i,
  input  logic          wr_pin_i,
  input  logic          sw_wen_i,
  input  logic          flash_on_i,
  input  logic          prog_lock_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_we_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic [NB-1:0] blk_en_o,
  output logic          erase_ok_o
);
  ebs_ctl_t      ctl;
  logic [LW-1:0] lo_q, lo_d;
  logic [HW-1:0] hi_q, hi_d;

  ebs_cond u_cond (
    .hw_stby_i  (hw_stby_i),
    .sw_stby_i  (sw_stby_i),
    .wr_pin_i   (wr_pin_i),
    .sw_wen_i   (sw_wen_i),
    .flash_on_i (flash_on_i),
    .prog_lock_i(prog_lock_i),
    .ctl_o      (ctl)
  );

  ebs_wr #(.DW(DW), .LW(LW), .HW(HW), .AW(AW), .LOA(LOA), .HIA(HIA)) u_wr (
    .ctl_i  (ctl),
    .lo_q_i (lo_q),
    .hi_q_i (hi_q),
    .addr_i (bus_addr_i),
    .we_i   (bus_we_i),
    .wdata_i(bus_wdata_i),
    .lo_d_o (lo_d),
    .hi_d_o (hi_d)
  );

  ebs_regs #(.LW(LW), .HW(HW)) u_regs (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lo_d_i(lo_d),
    .hi_d_i(hi_d),
    .lo_q_o(lo_q),
    .hi_q_o(hi_q)
  );

  ebs_rd #(.DW(DW), .LW(LW), .HW(HW), .AW(AW), .LOA(LOA), .HIA(HIA)) u_rd (
    .ctl_i     (ctl),
    .flash_on_i(flash_on_i),
    .lo_q_i    (lo_q),
    .hi_q_i    (hi_q),
    .addr_i    (bus_addr_i),
    .rdata_o   (bus_rdata_o),
    .blk_en_o  (blk_en_o),
    .erase_ok_o(erase_ok_o)
  );
endmodule

// File: rtl/erase_blk_sel_chk.sv
module erase_blk_sel_chk #(
  parameter int DW = 8,
  parameter int LW = 8,
  parameter int HW = 4,
  parameter int AW = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hw_stby_i,
  input logic          sw_stby_i,
  input logic          wr_pin_i,
  input logic          sw_wen_i,
  input logic          flash_on_i,
  input logic          prog_lock_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic [LW+HW-1:0] blk_en_o,
  input logic          erase_ok_o,
  input logic [LW-1:0] lo_q,
  input logic [HW-1:0] hi_q
);
  // R2
  clear_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_stby_i || sw_stby_i || !wr_pin_i) |=> (lo_q == '0 && hi_q == '0));

  // R3
  lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_pin_i && !sw_wen_i) |=> (lo_q == '0));

  // R7
  lock_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_lock_i |=> (lo_q == '0));

  // R5
  single_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hi_q, lo_q}) <= 1);

  // R6
  flash_off_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_on_i |-> (bus_rdata_o == '0 && blk_en_o == '0 && !erase_ok_o));

  // R6
  flash_off_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_on_i && wr_pin_i && sw_wen_i && !prog_lock_i && !hw_stby_i && !sw_stby_i)
      |=> ($stable(lo_q) && $stable(hi_q)));

  // R8
  erase_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_ok_o |-> ($onehot({hi_q, lo_q}) && flash_on_i && wr_pin_i && sw_wen_i
                    && !hw_stby_i && !sw_stby_i));

  // R4
  hi_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == AW'(1)) |-> (bus_rdata_o[DW-1:HW] == '0));
endmodule

bind erase_blk_sel erase_blk_sel_chk #(.DW(DW), .LW(LW), .HW(HW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hw_stby_i  (hw_stby_i),
  .sw_stby_i  (sw_stby_i),
  .wr_pin_i   (wr_pin_i),
  .sw_wen_i   (sw_wen_i),
  .flash_on_i (flash_on_i),
  .prog_lock_i(prog_lock_i),
  .bus_addr_i (bus_addr_i),
  .bus_rdata_o(bus_rdata_o),
  .blk_en_o   (blk_en_o),
  .erase_ok_o (erase_ok_o),
  .lo_q       (lo_q),
  .hi_q       (hi_q)
);

// File: tb/tb_erase_blk_sel.sv
module tb_erase_blk_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hw = 1'b0, ss = 1'b0, pin = 1'b1, swen = 1'b1, fon = 1'b1, lock = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [7:0]  wd = '0;
  logic [7:0]  rdata;
  logic [11:0] blk_en;
  logic        eok;
  logic [7:0]  m_lo = '0;
  logic [3:0]  m_hi = '0;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  erase_blk_sel dut (
    .clk_i(clk), .rst_ni(rst_ni), .hw_stby_i(hw), .sw_stby_i(ss), .wr_pin_i(pin),
    .sw_wen_i(swen), .flash_on_i(fon), .prog_lock_i(lock), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wd), .bus_rdata_o(rdata), .blk_en_o(blk_en),
    .erase_ok_o(eok)
  );

  function automatic logic [11:0] model_next(logic [11:0] cur);
    logic [7:0]  b_lo, c_lo;
    logic [3:0]  c_hi;
    logic        clr, hold, wok;
    clr  = hw | ss | !pin;
    hold = (pin & !swen) | lock;
    wok  = fon & !clr;
    b_lo = hold ? 8'h00 : cur[7:0];
    c_lo = b_lo;
    c_hi = cur[11:8];
    if (we && wok && addr == 2'd0 && !hold) c_lo = wd;
    if (we && wok && addr == 2'd1) c_hi = wd[3:0];
    if (clr) return 12'h000;
    if ($countones({c_hi, c_lo}) > 1) return {cur[11:8], b_lo};
    return {c_hi, c_lo};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(string tag);
    logic [11:0] all;
    all = {m_hi, m_lo};
    we = 1'b0;
    chk({tag, " blk_en R4"}, 32'(blk_en), fon ? 32'(all) : 32'h0);
    chk({tag, " erase_ok R8"}, 32'(eok),
        32'(fon & pin & swen & !hw & !ss & ($countones(all) == 1)));
    addr = 2'd0; #1;
    chk({tag, " read lo R9"}, 32'(rdata), fon ? 32'(m_lo) : 32'h0);
    addr = 2'd1; #1;
    chk({tag, " read hi R4"}, 32'(rdata), fon ? 32'(m_hi) : 32'h0);
    addr = 2'd2; #1;
    chk({tag, " read unmapped R10"}, 32'(rdata), 32'h0);
    addr = 2'd3; #1;
    chk({tag, " read unmapped R10"}, 32'(rdata), 32'h0);
  endtask

  task automatic step(string tag);
    logic [11:0] nxt;
    nxt = model_next({m_hi, m_lo});
    @(posedge clk);
    @(negedge clk);
    {m_hi, m_lo} = nxt;
    check_outputs(tag);
  endtask

  task automatic wr(string tag, logic [1:0] a, logic [7:0] d);
    addr = a; wd = d; we = 1'b1;
    step(tag);
  endtask

  task automatic idle(string tag);
    we = 1'b0;
    step(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    // R1: reset state
    repeat (2) @(negedge clk);
    check_outputs("R1 reset");
    rst_ni = 1'b1;
    idle("R1 after release");

    // R9 / R4 / R8: single low bit
    wr("R9 lo write", 2'd0, 8'h04);
    // R5: second bit in high register rejected
    wr("R5 hi reject", 2'd1, 8'h01);
    wr("R5 lo two bits", 2'd0, 8'h81);
    wr("R5 clear lo", 2'd0, 8'h00);
    wr("R5 hi two bits", 2'd1, 8'h03);
    // R4: upper nibble dropped
    wr("R4 hi upper", 2'd1, 8'hF2);
    // R10: unmapped write
    wr("R10 unmapped", 2'd2, 8'h00);
    wr("R10 unmapped", 2'd3, 8'h00);
    // R6: flash off masks and blocks writes
    fon = 1'b0;
    idle("R6 masked");
    wr("R6 write ignored", 2'd1, 8'h00);
    fon = 1'b1;
    idle("R6 restored");
    // R3: sw enable low holds low reg, high stays writable
    swen = 1'b0;
    idle("R3 hold");
    wr("R3 lo ignored", 2'd0, 8'h10);
    wr("R3 hi writable", 2'd1, 8'h00);
    wr("R3 hi set", 2'd1, 8'h04);
    swen = 1'b1;
    idle("R3 released");
    // R7: lock mode
    wr("R7 clear hi", 2'd1, 8'h00);
    lock = 1'b1;
    wr("R7 lo blocked", 2'd0, 8'h01);
    wr("R7 hi ok", 2'd1, 8'h08);
    lock = 1'b0;
    wr("R7 lo after lock", 2'd0, 8'h20);
    // R2: each clear source beats a write
    wr("R2 prep", 2'd1, 8'h00);
    wr("R2 prep", 2'd0, 8'h02);
    hw = 1'b1; wr("R2 hw standby", 2'd1, 8'h01); hw = 1'b0;
    wr("R2 prep", 2'd1, 8'h02);
    ss = 1'b1; wr("R2 sw standby", 2'd0, 8'h00); ss = 1'b0;
    wr("R2 prep", 2'd0, 8'h40);
    pin = 1'b0; wr("R2 pin low", 2'd0, 8'h40); pin = 1'b1;
    idle("R2 after");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      hw   = ($urandom % 16) == 0;
      ss   = ($urandom % 16) == 0;
      pin  = ($urandom % 8) != 0;
      swen = ($urandom % 8) != 0;
      fon  = ($urandom % 8) != 0;
      lock = ($urandom % 10) == 0;
      addr = 2'($urandom % 4);
      we   = ($urandom % 4) != 0;
      case ($urandom % 4)
        0: wd = 8'h00;
        1: wd = 8'hFF & $urandom;
        default: wd = 8'h01 << ($urandom % 8);
      endcase
      step("rand R2 R3 R5 R6 R7");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule